// File: doc/BRIEF.md
# Parallel-bus converter sequence controller

This block is the host-side master for a four-channel, simultaneously sampling 12-bit converter that sits on a chip-select/read/write parallel bus. Each time it receives a start request, it does three things. It writes the channel-enable mask into the converter. It pulses the convert-start line. It then collects one 12-bit word for every enabled channel into a result array indexed by channel. A one-cycle done pulse marks that the array is complete.

Two read schedules are available. In the first, each word is fetched as soon as the converter signals that its conversion has ended, so reading overlaps the remaining conversions. In the second, the block waits until the converter drops its busy line and then reads all the words back to back. On the first read of every sequence the block checks the converter's first-word marker, and it latches a sticky error if that marker is low.

The block also manages the converter's standby line, and it holds off any conversion until a wake-up interval has passed. Every bus timing minimum is a parameter given in nanoseconds and converted to a whole number of system clock cycles, rounding up.

Top module: `adc_host_ctrl`

## Requirements
- R1: Before each conversion the mask is written to the converter, with bit i enabling channel i. For this write, `cs_n_o` is low and `rd_n_o` is high. `wr_n_o` goes low for at least one cycle (20 ns at the default timing). `db_o` is driven with `db_oe_o` high for at least one cycle before and one cycle after the rising edge of `wr_n_o`. The converter captures the mask on that rising edge.
- R2: `stby_o` follows `wake_i` one cycle later. A start request made while the converter is in standby is held. `convst_o` does not rise until at least 100 cycles (2 us) after `stby_o` has risen.
- R3: Each sequence produces one `convst_o` high pulse of 2 cycles. Every read holds `rd_n_o` low, with `cs_n_o` low, for at least 2 cycles (35 ns of pulse width and access time). The word is taken on the last low cycle.
- R4: Between two consecutive reads, `rd_n_o` is high for at least one cycle. `rd_n_o` and `wr_n_o` are never low at the same time.
- R5: With `mode_i`=0, each falling edge of `eoc_n_i` starts exactly one read, and that read begins while `busy_i` is still high. The number of reads equals the number of enabled channels.
- R6: With `mode_i`=1, no read starts while `busy_i` is high. After `busy_i` falls, the block performs one read per enabled channel, back to back.
- R7: The k-th word read is stored in the slice `result_o[ch*12 +: 12]` of the k-th lowest enabled channel `ch`. The slices of disabled channels keep their previous values.
- R8: If `frstdata_i` is low during the first read of a sequence, `align_err_o` is set. It stays set through later, correctly aligned sequences until reset.
- R9: `done_o` is a single-cycle pulse that follows the storing of the last word. `result_o` is complete while `done_o` is high.
- R10: A `start_i` that arrives while `active_o` is high, or in the same cycle as `done_o`, is held. It is then served as a further, complete sequence.
- R11: A start request with an all-zero mask completes with a `done_o` pulse. No `cs_n_o` low cycle and no `convst_o` pulse occur for it.
- R12: After reset, `cs_n_o`, `rd_n_o` and `wr_n_o` are high. `convst_o`, `stby_o`, `done_o`, `align_err_o` and `active_o` are low, and `result_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 1 | Request the converter to leave standby |
| start_i | input | 1 | Start-sequence request pulse |
| mode_i | input | 1 | 0: read on each end-of-conversion, 1: read after busy falls |
| chan_mask_i | input | 4 | Channel enable mask, bit i = channel i |
| db_i | input | 12 | Data bus from the converter |
| eoc_n_i | input | 1 | End-of-conversion pulse, active low |
| busy_i | input | 1 | Converter sequence busy |
| frstdata_i | input | 1 | Converter first-word marker |
| stby_o | output | 1 | Converter run line (high = running, low = standby) |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| convst_o | output | 1 | Convert start, rising edge starts the sequence |
| db_o | output | 4 | Mask value driven on the low data lines |
| db_oe_o | output | 1 | Output enable for `db_o` |
| result_o | output | 48 | Result array, channel ch at bits ch*12 +: 12 |
| done_o | output | 1 | Sequence-complete pulse |
| align_err_o | output | 1 | Sticky first-word alignment error |
| active_o | output | 1 | A sequence is in progress |

## Verification
Two events can meet in a single clock cycle: the done pulse that closes one sequence, and a new start request that has to be held for the next. The bench provokes this by raising `start_i` in the exact cycle in which `done_o` is high. It then judges the outcome by requiring a second complete sequence, with its own mask write and done pulse. In the same way, a start issued in the middle of a sequence must produce one extra completed sequence, and must not disturb the sequence already running.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_WR_SU, SQ_WR_LO, SQ_WR_HD, SQ_CONV,
    SQ_WAIT_BHI, SQ_WAIT_EVT, SQ_RD_LO, SQ_RD_GAP, SQ_DONE
  } seq_state_t;

  // Round a nanosecond minimum up to whole clock cycles, at least one.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_wake_timer.sv
`timescale 1ns/1ps
module adc_wake_timer #(
  parameter int WAKE_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_i,
  output logic stby_o,
  output logic awake_o
);
  localparam int WW = $clog2(WAKE_CYC + 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stby_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stby_o <= wake_i;
      if (wake_i && !stby_o)
        cnt_q <= WW'(WAKE_CYC);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign awake_o = stby_o && (cnt_q == '0);

  // R2: the run line rising never counts as already awake
  assert_wake_wait_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(stby_o) |-> !awake_o);

endmodule

// File: rtl/adc_chan_pick.sv
`timescale 1ns/1ps
module adc_chan_pick #(
  parameter int NCH = 4,
  parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] mask_i,
  output logic [IW-1:0]  idx_o,
  output logic           any_o
);
  logic [NCH:0]   below;
  logic [NCH-1:0] lowest;

  assign below[0] = 1'b0;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_pri
      assign lowest[i]   = mask_i[i] & ~below[i];
      assign below[i+1]  = below[i] | mask_i[i];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NCH; i++)
      if (lowest[i]) idx_o = IW'(i);
  end

  assign any_o = below[NCH];

  // R7: exactly one channel is chosen whenever any is pending
  always_comb begin
    if (any_o) begin
      assert_one_pick_R7: assert ($onehot0(lowest) && (lowest != '0));
    end
  end

endmodule

// File: rtl/adc_result_bank.sv
`timescale 1ns/1ps
module adc_result_bank #(
  parameter int NCH = 4,
  parameter int DW  = 12,
  parameter int IW  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DW-1:0]     data_i,
  output logic [NCH*DW-1:0] flat_o
);
  logic [DW-1:0] mem_q [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= data_i;
    end
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_out
      assign flat_o[i*DW +: DW] = mem_q[i];
    end
  endgenerate

endmodule

// File: rtl/adc_host_ctrl.sv
`timescale 1ns/1ps
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int DW        = 12,
  parameter int CLK_NS    = 20,
  parameter int WR_SU_NS  = 5,
  parameter int WR_LO_NS  = 20,
  parameter int WR_HD_NS  = 5,
  parameter int CONV_NS   = 40,
  parameter int RD_LO_NS  = 35,
  parameter int RD_ACC_NS = 35,
  parameter int RD_GAP_NS = 10,
  parameter int WAKE_NS   = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake_i,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [NCH-1:0]    chan_mask_i,
  input  logic [DW-1:0]     db_i,
  input  logic              eoc_n_i,
  input  logic              busy_i,
  input  logic              frstdata_i,
  output logic              stby_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              convst_o,
  output logic [NCH-1:0]    db_o,
  output logic              db_oe_o,
  output logic [NCH*DW-1:0] result_o,
  output logic              done_o,
  output logic              align_err_o,
  output logic              active_o
);
  localparam int SU_C   = ns_to_cyc(WR_SU_NS, CLK_NS);
  localparam int WR_C   = ns_to_cyc(WR_LO_NS, CLK_NS);
  localparam int HD_C   = ns_to_cyc(WR_HD_NS, CLK_NS);
  localparam int CV_C   = ns_to_cyc(CONV_NS, CLK_NS);
  localparam int RD_C   = imax(ns_to_cyc(RD_LO_NS, CLK_NS), ns_to_cyc(RD_ACC_NS, CLK_NS));
  localparam int GAP_C  = ns_to_cyc(RD_GAP_NS, CLK_NS);
  localparam int WAKE_C = ns_to_cyc(WAKE_NS, CLK_NS);
  localparam int MAXC   = imax(imax(imax(SU_C, WR_C), imax(HD_C, CV_C)), imax(RD_C, GAP_C));
  localparam int TW     = $clog2(MAXC + 1);
  localparam int IW     = (NCH > 1) ? $clog2(NCH) : 1;

  seq_state_t     st_q, st_d;
  logic [TW-1:0]  t_q, t_d;
  logic [NCH-1:0] rem_q;
  logic           mode_q, first_q, pend_q, eoc_q, evt_q, evt_d;
  logic           awake, leave_idle, store, eoc_fall, consume;
  logic [IW-1:0]  pick_idx;
  logic           pick_any;

  adc_wake_timer #(.WAKE_CYC(WAKE_C)) u_wake (
    .clk(clk), .rst(rst), .wake_i(wake_i), .stby_o(stby_o), .awake_o(awake));

  adc_chan_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .mask_i(rem_q), .idx_o(pick_idx), .any_o(pick_any));

  adc_result_bank #(.NCH(NCH), .DW(DW), .IW(IW)) u_bank (
    .clk(clk), .rst(rst), .we_i(store), .idx_i(pick_idx), .data_i(db_i), .flat_o(result_o));

  assign eoc_fall = eoc_q && !eoc_n_i && (st_q != SQ_IDLE);

  always_comb begin
    st_d       = st_q;
    t_d        = (t_q != '0) ? t_q - 1'b1 : '0;
    leave_idle = 1'b0;
    store      = 1'b0;
    consume    = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (pend_q && awake) begin
        leave_idle = 1'b1;
        if (chan_mask_i == '0) st_d = SQ_DONE;
        else begin st_d = SQ_WR_SU; t_d = TW'(SU_C - 1); end
      end
      SQ_WR_SU: if (t_q == '0) begin st_d = SQ_WR_LO; t_d = TW'(WR_C - 1); end
      SQ_WR_LO: if (t_q == '0) begin st_d = SQ_WR_HD; t_d = TW'(HD_C - 1); end
      SQ_WR_HD: if (t_q == '0) begin st_d = SQ_CONV;  t_d = TW'(CV_C - 1); end
      SQ_CONV:  if (t_q == '0) st_d = SQ_WAIT_BHI;
      SQ_WAIT_BHI: if (busy_i) st_d = SQ_WAIT_EVT;
      SQ_WAIT_EVT: begin
        if (mode_q ? !busy_i : (evt_q || eoc_fall)) begin
          consume = !mode_q;
          st_d    = SQ_RD_LO;
          t_d     = TW'(RD_C - 1);
        end
      end
      SQ_RD_LO: if (t_q == '0) begin
        store = 1'b1;
        st_d  = SQ_RD_GAP;
        t_d   = TW'(GAP_C - 1);
      end
      SQ_RD_GAP: if (t_q == '0) st_d = pick_any ? SQ_WAIT_EVT : SQ_DONE;
      SQ_DONE:  st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
    evt_d = consume ? (evt_q && eoc_fall) : (evt_q || eoc_fall);
    if (leave_idle) evt_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= SQ_IDLE;
      t_q         <= '0;
      rem_q       <= '0;
      mode_q      <= 1'b0;
      first_q     <= 1'b0;
      pend_q      <= 1'b0;
      eoc_q       <= 1'b1;
      evt_q       <= 1'b0;
      db_o        <= '0;
      cs_n_o      <= 1'b1;
      rd_n_o      <= 1'b1;
      wr_n_o      <= 1'b1;
      convst_o    <= 1'b0;
      db_oe_o     <= 1'b0;
      done_o      <= 1'b0;
      active_o    <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      t_q    <= t_d;
      eoc_q  <= eoc_n_i;
      evt_q  <= evt_d;
      pend_q <= start_i | (pend_q & ~leave_idle);
      if (leave_idle) begin
        rem_q   <= chan_mask_i;
        mode_q  <= mode_i;
        first_q <= 1'b1;
        db_o    <= chan_mask_i;
      end
      if (store) begin
        rem_q[pick_idx] <= 1'b0;
        first_q         <= 1'b0;
        if (first_q && !frstdata_i) align_err_o <= 1'b1;
      end
      cs_n_o   <= !(st_d inside {SQ_WR_SU, SQ_WR_LO, SQ_WR_HD, SQ_RD_LO});
      wr_n_o   <= (st_d != SQ_WR_LO);
      rd_n_o   <= (st_d != SQ_RD_LO);
      convst_o <= (st_d == SQ_CONV);
      db_oe_o  <= (st_d inside {SQ_WR_SU, SQ_WR_LO, SQ_WR_HD});
      done_o   <= (st_d == SQ_DONE);
      active_o <= (st_d != SQ_IDLE);
    end
  end

  // Width of each read strobe, counted for the checker below.
  logic [TW:0] rd_lo_cnt;
  always_ff @(posedge clk) begin
    if (rst || rd_n_o) rd_lo_cnt <= '0;
    else if (rd_lo_cnt != '1) rd_lo_cnt <= rd_lo_cnt + 1'b1;
  end

  assert_rd_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n_o) |-> (rd_lo_cnt >= (TW+1)'(RD_C)));
  assert_rd_sel_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_n_o |-> !cs_n_o);
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n_o && !wr_n_o));
  assert_wr_data_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n_o) |-> ($stable(db_o) && db_oe_o && !cs_n_o && rd_n_o));
  assert_conv_awake_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(convst_o) |-> stby_o);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    align_err_o |=> align_err_o);

endmodule

// File: tb/adc_host_ctrl_tb.sv
`timescale 1ns/1ps
module adc_host_ctrl_tb;
  localparam int CONV_T = 20;
  localparam int WAKE_C = 100;

  logic clk = 1'b0, rst = 1'b1;
  logic wake_i = 1'b0, start_i = 1'b0, mode_i = 1'b0;
  logic [3:0] chan_mask_i = '0;
  logic [11:0] db_i;
  logic eoc_n_i, busy_i, frstdata_i;
  logic stby_o, cs_n_o, rd_n_o, wr_n_o, convst_o, db_oe_o, done_o, align_err_o, active_o;
  logic [3:0] db_o;
  logic [47:0] result_o;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  adc_host_ctrl u_dut (
    .clk(clk), .rst(rst), .wake_i(wake_i), .start_i(start_i), .mode_i(mode_i),
    .chan_mask_i(chan_mask_i), .db_i(db_i), .eoc_n_i(eoc_n_i), .busy_i(busy_i),
    .frstdata_i(frstdata_i), .stby_o(stby_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o), .convst_o(convst_o), .db_o(db_o), .db_oe_o(db_oe_o),
    .result_o(result_o), .done_o(done_o), .align_err_o(align_err_o), .active_o(active_o));

  function automatic logic [11:0] word(input logic [7:0] s, input int ch);
    return {s, 2'(ch), 2'b10};
  endfunction

  // ---------------- converter model ----------------
  logic [7:0] seed = 8'h00;
  logic skew = 1'b0;
  logic [3:0] m_mask;
  logic m_busy, m_eoc_n;
  int m_q[4];
  int m_n, m_cidx, m_ct, m_et, m_rptr;
  logic p_wr_n, p_rd_n, p_convst, p_stby, p_done;
  int reads, rd_busy, early, eoc_cnt, cs_cyc, cv_cnt, rd_viol, dbl_done;
  int rdlo, rdhi, since_stby, last_gap;

  assign busy_i  = m_busy;
  assign eoc_n_i = m_eoc_n;
  assign frstdata_i = (m_rptr == 0) && !skew;
  always_comb begin
    db_i = '0;
    if (!rd_n_o && !cs_n_o && m_rptr < m_n) db_i = word(seed, m_q[m_rptr]);
  end

  always @(negedge clk) begin
    if (rst) begin
      m_mask = '0; m_busy = 0; m_eoc_n = 1; m_n = 0; m_cidx = 0; m_ct = 0; m_et = 0; m_rptr = 0;
      for (int i = 0; i < 4; i++) m_q[i] = 0;
      p_wr_n = 1; p_rd_n = 1; p_convst = 0; p_stby = 0; p_done = 0;
      reads = 0; rd_busy = 0; early = 0; eoc_cnt = 0; cs_cyc = 0; cv_cnt = 0;
      rd_viol = 0; dbl_done = 0; rdlo = 0; rdhi = 9; since_stby = 0; last_gap = 0;
    end else begin
      if (!p_wr_n && wr_n_o && !cs_n_o) m_mask = db_o;
      if (!p_convst && convst_o) begin
        cv_cnt++; last_gap = since_stby;
        m_n = 0; m_rptr = 0; eoc_cnt = 0; reads = 0;
        for (int c = 0; c < 4; c++) if (m_mask[c]) begin m_q[m_n] = c; m_n++; end
        if (m_n > 0) begin m_busy = 1; m_cidx = 0; m_ct = CONV_T; end
      end else if (m_busy) begin
        if (m_et > 0) begin
          m_et--;
          if (m_et == 0) begin
            m_eoc_n = 1; m_cidx++;
            if (m_cidx == m_n) m_busy = 0; else m_ct = CONV_T;
          end
        end else begin
          m_ct--;
          if (m_ct == 0) begin m_eoc_n = 0; m_et = 4; eoc_cnt++; end
        end
      end
      if (p_rd_n && !rd_n_o) begin
        if (rdhi < 1) rd_viol++;
        reads++; rdlo = 0;
        if (m_busy) rd_busy++;
        if (!mode_i && reads > eoc_cnt) early++;
      end
      if (!rd_n_o) rdlo++;
      if (!p_rd_n && rd_n_o) begin m_rptr++; if (rdlo < 2) rd_viol++; rdhi = 0; end
      if (rd_n_o) rdhi++;
      if (!cs_n_o) cs_cyc++;
      if (done_o && p_done) dbl_done++;
      if (!p_stby && stby_o) since_stby = 0; else since_stby++;
      p_wr_n = wr_n_o; p_rd_n = rd_n_o; p_convst = convst_o; p_stby = stby_o; p_done = done_o;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_o) begin ok = 1'b1; break; end
    end
    #2;
  endtask

  logic [11:0] expv [4];

  task automatic chk_results(input string req);
    for (int c = 0; c < 4; c++)
      chk(result_o[c*12 +: 12] == expv[c], req, "result slice",
          result_o[c*12 +: 12], expv[c]);
  endtask

  // mode, mask, seed
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 4'hF, 8'h11}, {1'b1, 4'hF, 8'h22}, {1'b0, 4'h5, 8'h33},
    {1'b1, 4'hA, 8'h44}, {1'b0, 4'h8, 8'h55}, {1'b1, 4'h1, 8'h66}};

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ok;
    int cs0, cv0, pc, rb0;
    for (int c = 0; c < 4; c++) expv[c] = '0;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(cs_n_o && rd_n_o && wr_n_o, "R12", "strobes idle high", {cs_n_o, rd_n_o, wr_n_o}, 3'b111);
    chk(!convst_o && !stby_o && !done_o && !active_o, "R12", "controls low",
        {convst_o, stby_o, done_o, active_o}, 0);
    chk(!align_err_o && result_o == '0, "R12", "error/results clear", result_o, 0);
    rst = 1'b0;
    wake_i = 1'b1;
    repeat (3) @(negedge clk);
    #2 chk(stby_o == 1'b1, "R2", "run line follows wake", stby_o, 1);

    // vector table
    for (int v = 0; v < 6; v++) begin
      mode_i = VEC[v][12]; chan_mask_i = VEC[v][11:8]; seed = VEC[v][7:0];
      rb0 = rd_busy;
      pc = $countones(VEC[v][11:8]);
      pulse_start();
      wait_done(ok);
      chk(ok, "R9", "done pulse seen", ok, 1);
      for (int c = 0; c < 4; c++) if (VEC[v][8+c]) expv[c] = word(VEC[v][7:0], c);
      chk_results("R7");
      chk(m_mask == VEC[v][11:8], "R1", "mask written", m_mask, VEC[v][11:8]);
      chk(reads == pc, VEC[v][12] ? "R6" : "R5", "reads per sequence", reads, pc);
      if (VEC[v][12]) chk(rd_busy - rb0 == 0, "R6", "reads while busy", rd_busy - rb0, 0);
      else chk(rd_busy - rb0 == pc, "R5", "reads overlapping busy", rd_busy - rb0, pc);
      chk(align_err_o == 1'b0, "R8", "no alignment error", align_err_o, 0);
      repeat (3) @(negedge clk);
    end
    #2;
    chk(rd_viol == 0, "R3", "read strobe width/gap violations (R4)", rd_viol, 0);
    chk(early == 0, "R5", "reads ahead of end-of-conversion", early, 0);
    chk(dbl_done == 0, "R9", "done wider than one cycle", dbl_done, 0);
    chk(cv_cnt == 6, "R3", "one convert pulse per sequence", cv_cnt, 6);

    // R11 empty mask
    cs0 = cs_cyc; cv0 = cv_cnt;
    chan_mask_i = 4'h0; mode_i = 1'b0;
    pulse_start();
    wait_done(ok);
    chk(ok, "R11", "done for empty mask", ok, 1);
    chk(cs_cyc == cs0 && cv_cnt == cv0, "R11", "no bus activity", cs_cyc - cs0, 0);

    // R10 start during an active sequence
    chan_mask_i = 4'hC; mode_i = 1'b0; seed = 8'h77;
    cv0 = cv_cnt;
    pulse_start();
    repeat (8) @(negedge clk);
    #2 chk(active_o == 1'b1, "R10", "sequence active", active_o, 1);
    pulse_start();
    wait_done(ok);
    wait_done(ok);
    chk(ok, "R10", "held request completes", ok, 1);
    chk(cv_cnt - cv0 == 2, "R10", "two sequences run", cv_cnt - cv0, 2);
    expv[2] = word(8'h77, 2); expv[3] = word(8'h77, 3);
    chk_results("R7");

    // R10 start in the same cycle as done
    chan_mask_i = 4'h2; mode_i = 1'b1; seed = 8'h88;
    cv0 = cv_cnt;
    pulse_start();
    for (int i = 0; i < 3000 && !done_o; i++) @(negedge clk);
    seed = 8'h99; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done(ok);
    chk(ok, "R10", "request coinciding with done served", ok, 1);
    chk(cv_cnt - cv0 == 2, "R10", "coinciding request sequences", cv_cnt - cv0, 2);
    expv[1] = word(8'h99, 1);
    chk_results("R7");

    // R8 alignment error, then sticky
    skew = 1'b1; chan_mask_i = 4'h3; mode_i = 1'b1; seed = 8'hAB;
    pulse_start();
    wait_done(ok);
    chk(align_err_o == 1'b1, "R8", "misaligned first word flagged", align_err_o, 1);
    skew = 1'b0;
    pulse_start();
    wait_done(ok);
    chk(align_err_o == 1'b1, "R8", "flag sticky after good sequence", align_err_o, 1);
    expv[0] = word(8'hAB, 0); expv[1] = word(8'hAB, 1);
    chk_results("R7");

    // R2 standby: request held, wake-up interval respected
    wake_i = 1'b0;
    repeat (3) @(negedge clk);
    #2 chk(stby_o == 1'b0, "R2", "standby asserted", stby_o, 0);
    cv0 = cv_cnt; chan_mask_i = 4'h4; mode_i = 1'b0; seed = 8'h5A;
    pulse_start();
    repeat (30) @(negedge clk);
    #2 chk(cv_cnt == cv0 && !active_o, "R2", "held while in standby", cv_cnt - cv0, 0);
    wake_i = 1'b1;
    wait_done(ok);
    chk(ok, "R2", "sequence after wake-up", ok, 1);
    chk(last_gap >= WAKE_C, "R2", "cycles run-line rise to convert", last_gap, WAKE_C);
    expv[2] = word(8'h5A, 2);
    chk_results("R7");

    // R12 reset again clears sticky state and results
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(!align_err_o && result_o == '0, "R12", "reset clears error and results", align_err_o, 0);
    chk(cs_n_o && rd_n_o && wr_n_o && !convst_o, "R12", "bus idle after reset",
        {cs_n_o, rd_n_o, wr_n_o, convst_o}, 4'b1110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule